// File: doc/BRIEF.md
# SMBus Event Router

This block collects the events reported by an SMBus host engine and an SMBus target engine and routes them to three system outputs: an interrupt line, a management-interrupt (SMI) line and a wake request. Its inputs are four host completion events, the active-low alert pin, a target command that asks for wake or SMI, a host-notify reception event and a system-asleep flag. Each event sets a sticky status bit. Software clears a status bit by writing one to it.

The routing rules are evaluated independently, so a single event, or several events in the same cycle, may drive more than one output at once. The interrupt and SMI lines are levels. They are derived at every cycle from the sticky status and the current enable settings, so clearing a bit or changing an enable takes effect at once. The wake request is a one-cycle pulse that follows the event that qualifies for it. The alert pin is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops before its falling edge is detected.

Top module: `smb_evt_router`

## Requirements
- R1: After reset, `status_o` is 0x00 and `irq_o`, `smi_o` and `wake_o` are all low.
- R2: Each high-to-low transition of `alert_n` sets status bit 5 and requests wake, whatever the enable inputs are. A pin sample taken at clock edge k takes effect at edge k+SYNC_STAGES (SYNC_STAGES defaults to 2). Keeping the pin low does not set bit 5 again after software has cleared it.
- R3: While status bit 5 is set, `smi_o` is high whenever `smi_en_i`=1 and `alert_dis_i`=0.
- R4: While status bit 5 is set, `irq_o` is high whenever `irq_en_i`=1, `smi_en_i`=0 and `alert_dis_i`=0. No other combination lets the alert reach `irq_o`.
- R5: A pulse on `host_evt_i[n]` sets status bit n+1 (bits 4..1). While any of these bits is set, the outputs follow the enables. With `irq_en_i`=0 nothing is produced. With `irq_en_i`=1 and `smi_en_i`=0, `irq_o` is high. With both enables at 1, `smi_o` is high.
- R6: A pulse on `tgt_wake_cmd_i` behaves according to `sys_asleep_i`. While `sys_asleep_i`=1, it produces a wake pulse and sets no status. While `sys_asleep_i`=0, it sets status bit 6, and bit 6 drives `smi_o` high regardless of the enables.
- R7: A pulse on `notify_evt_i` sets status bit 0. If `ntf_wake_en_i`=1, the pulse also requests wake. While bit 0 is set and `ntf_irq_en_i`=1, the output depends on `smi_en_i`: `irq_o` is high when it is 0, and `smi_o` is high when it is 1.
- R8: All rules apply at the same time, so one cycle's events can raise `irq_o`, `smi_o` and `wake_o` together.
- R9: A cycle with `sts_wr_en_i`=1 clears every status bit whose `sts_wr_data_i` bit is 1. Bits written 0 keep their value. If an event sets a bit in the same cycle that the write clears it, the bit stays set. Bit 7 always reads 0.
- R10: An event pulse sampled at edge k makes `wake_o` high for exactly the one cycle after edge k. A held-low alert pin gives a single pulse.
- R11: `irq_o` and `smi_o` are levels. They remain high while a qualifying status bit is set, and they fall in the same cycle that the bit is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alert_n | input | 1 | Asynchronous active-low alert pin |
| host_evt_i | input | 4 | Host completion event pulses, set status bits 4..1 |
| tgt_wake_cmd_i | input | 1 | Target wake/SMI command received (pulse) |
| notify_evt_i | input | 1 | Host-notify message received (pulse) |
| sys_asleep_i | input | 1 | System is in a sleep state |
| irq_en_i | input | 1 | Host interrupt enable |
| smi_en_i | input | 1 | SMI steering enable |
| alert_dis_i | input | 1 | Blocks alert from interrupt and SMI |
| ntf_irq_en_i | input | 1 | Host-notify interrupt/SMI enable |
| ntf_wake_en_i | input | 1 | Host-notify wake enable |
| sts_wr_en_i | input | 1 | Status write-one-to-clear strobe |
| sts_wr_data_i | input | 8 | Status bits to clear |
| status_o | output | 8 | Sticky status vector |
| irq_o | output | 1 | Interrupt request level |
| smi_o | output | 1 | SMI request level |
| wake_o | output | 1 | Wake request pulse |

## Verification
A sticky bit that is lost or set wrongly shows on `status_o` in the first cycle after the event edge. Because `irq_o` and `smi_o` decode that status combinationally, a wrong bit also shows on them in the same cycle, unless the enables happen to mask it. A routing fault is visible only when the enable combination selects the faulty path. For that reason the enables are changed while status is held, and the levels are compared in every cycle. A fault in the alert synchronizer or in the edge detector shifts the alert's arrival by a cycle or repeats it. The bench sees this as a misplaced or second wake pulse, or as bit 5 coming back after it was cleared while the pin stays low.

// File: rtl/smb_evt_pkg.sv
`timescale 1ns/1ps
package smb_evt_pkg;
  localparam int STS_W     = 8;
  localparam int HOST_W    = 4;
  localparam int NTF_BIT   = 0;
  localparam int HOST_LO   = 1;
  localparam int ALERT_BIT = 5;
  localparam int TCMD_BIT  = 6;

  typedef struct packed {
    logic irq_en;
    logic smi_en;
    logic alert_dis;
    logic ntf_irq_en;
    logic ntf_wake_en;
  } route_cfg_t;

  // Returns {smi, irq} for one pending source: when the path is open the
  // request goes to SMI if smi_sel is set, otherwise to the interrupt.
  function automatic logic [1:0] steer(input logic pending,
                                       input logic path_on,
                                       input logic smi_sel);
    logic [1:0] r;
    r = 2'b00;
    if (pending && path_on) begin
      if (smi_sel) r = 2'b10;
      else         r = 2'b01;
    end
    return r;
  endfunction
endpackage

// File: rtl/smb_alert_sync.sv
`timescale 1ns/1ps
module smb_alert_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alert_n,
  output logic alert_edge
);
  logic [STAGES-1:0] chain;
  logic              prev_q;
  logic              synced_n;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= alert_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], alert_n};
      end
    end
  endgenerate

  assign synced_n = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= synced_n;
  end

  assign alert_edge = prev_q & ~synced_n;

  // R10
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_edge |=> !alert_edge);
endmodule

// File: rtl/smb_evt_status.sv
`timescale 1ns/1ps
module smb_evt_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_vec : '0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sts[i] <= 1'b0;
        else if (set_vec[i]) sts[i] <= 1'b1;
        else if (clr_eff[i]) sts[i] <= 1'b0;
      end
    end
  endgenerate

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sts & $past(set_vec)) == $past(set_vec)));
  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((sts & $past(clr_vec & ~set_vec)) == '0));
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((sts & $past(sts)) == $past(sts)));
endmodule

// File: rtl/smb_evt_route.sv
`timescale 1ns/1ps
module smb_evt_route
  import smb_evt_pkg::*;
#(
  parameter int HW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  route_cfg_t    cfg,
  input  logic [HW-1:0] host_sts,
  input  logic          alert_sts,
  input  logic          ntf_sts,
  input  logic          tcmd_sts,
  input  logic          alert_edge,
  input  logic          tcmd_evt,
  input  logic          ntf_evt,
  input  logic          asleep,
  output logic          irq_o,
  output logic          smi_o,
  output logic          wake_o
);
  logic       host_any;
  logic [1:0] host_req;
  logic [1:0] alert_req;
  logic [1:0] ntf_req;
  logic [1:0] tcmd_req;
  logic       wake_src;
  logic       wake_q;

  assign host_any  = |host_sts;
  assign host_req  = steer(host_any,  cfg.irq_en, cfg.smi_en);
  assign alert_req = steer(alert_sts, ~cfg.alert_dis & (cfg.irq_en | cfg.smi_en),
                           cfg.smi_en);
  assign ntf_req   = steer(ntf_sts,   cfg.ntf_irq_en, cfg.smi_en);
  assign tcmd_req  = steer(tcmd_sts,  1'b1, 1'b1);

  assign irq_o = host_req[0] | alert_req[0] | ntf_req[0] | tcmd_req[0];
  assign smi_o = host_req[1] | alert_req[1] | ntf_req[1] | tcmd_req[1];

  assign wake_src = alert_edge | (tcmd_evt & asleep) | (ntf_evt & cfg.ntf_wake_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_src;
  end
  assign wake_o = wake_q;

  // R4
  irq_needs_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !cfg.smi_en);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_any && !alert_sts && !ntf_sts && !tcmd_sts) |-> (!irq_o && !smi_o));
  // R5
  host_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.irq_en && cfg.smi_en && host_any) |-> smi_o);
  // R10
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_src |=> !wake_o);
endmodule

// File: rtl/smb_evt_router.sv
`timescale 1ns/1ps
module smb_evt_router
  import smb_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alert_n,
  input  logic [HOST_W-1:0] host_evt_i,
  input  logic             tgt_wake_cmd_i,
  input  logic             notify_evt_i,
  input  logic             sys_asleep_i,
  input  logic             irq_en_i,
  input  logic             smi_en_i,
  input  logic             alert_dis_i,
  input  logic             ntf_irq_en_i,
  input  logic             ntf_wake_en_i,
  input  logic             sts_wr_en_i,
  input  logic [STS_W-1:0] sts_wr_data_i,
  output logic [STS_W-1:0] status_o,
  output logic             irq_o,
  output logic             smi_o,
  output logic             wake_o
);
  route_cfg_t       cfg;
  logic             alert_edge;
  logic             tcmd_awake;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] sts;

  assign cfg.irq_en      = irq_en_i;
  assign cfg.smi_en      = smi_en_i;
  assign cfg.alert_dis   = alert_dis_i;
  assign cfg.ntf_irq_en  = ntf_irq_en_i;
  assign cfg.ntf_wake_en = ntf_wake_en_i;

  smb_alert_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .alert_n    (alert_n),
    .alert_edge (alert_edge)
  );

  assign tcmd_awake = tgt_wake_cmd_i & ~sys_asleep_i;

  always_comb begin
    set_vec = '0;
    set_vec[NTF_BIT]                   = notify_evt_i;
    set_vec[HOST_LO +: HOST_W]         = host_evt_i;
    set_vec[ALERT_BIT]                 = alert_edge;
    set_vec[TCMD_BIT]                  = tcmd_awake;
  end

  smb_evt_status #(.W(STS_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_en  (sts_wr_en_i),
    .clr_vec (sts_wr_data_i),
    .sts     (sts)
  );

  smb_evt_route #(.HW(HOST_W)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .host_sts   (sts[HOST_LO +: HOST_W]),
    .alert_sts  (sts[ALERT_BIT]),
    .ntf_sts    (sts[NTF_BIT]),
    .tcmd_sts   (sts[TCMD_BIT]),
    .alert_edge (alert_edge),
    .tcmd_evt   (tgt_wake_cmd_i),
    .ntf_evt    (notify_evt_i),
    .asleep     (sys_asleep_i),
    .irq_o      (irq_o),
    .smi_o      (smi_o),
    .wake_o     (wake_o)
  );

  assign status_o = sts;

  // R2
  alert_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_edge |=> (status_o[ALERT_BIT] && wake_o));
  // R6
  tcmd_sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wake_cmd_i && sys_asleep_i) |=> wake_o);
  // R6
  tcmd_awake_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wake_cmd_i && !sys_asleep_i) |=> (status_o[TCMD_BIT] && smi_o));
  // R7
  notify_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_evt_i && ntf_wake_en_i) |=> (wake_o && status_o[NTF_BIT]));
  // R9
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[STS_W-1]);
endmodule

// File: tb/smb_evt_router_bench.sv
`timescale 1ns/1ps
module smb_evt_router_bench;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alert_n = 1'b1;
  logic [3:0] host_evt = 4'h0;
  logic       tcmd = 1'b0, ntf = 1'b0, asleep = 1'b0;
  logic       irq_en = 1'b0, smi_en = 1'b0, alert_dis = 1'b0;
  logic       ntf_irq_en = 1'b0, ntf_wake_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status;
  logic       irq, smi, wake;

  int n_chk = 0, n_fail = 0, wake_cnt = 0;

  always #10 clk = ~clk;

  smb_evt_router #(.SYNC_STAGES(S)) u_smb_evt_router (
    .clk(clk), .rst_n(rst_n), .alert_n(alert_n), .host_evt_i(host_evt),
    .tgt_wake_cmd_i(tcmd), .notify_evt_i(ntf), .sys_asleep_i(asleep),
    .irq_en_i(irq_en), .smi_en_i(smi_en), .alert_dis_i(alert_dis),
    .ntf_irq_en_i(ntf_irq_en), .ntf_wake_en_i(ntf_wake_en),
    .sts_wr_en_i(wr_en), .sts_wr_data_i(wr_data),
    .status_o(status), .irq_o(irq), .smi_o(smi), .wake_o(wake));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: pin history, sticky bits, wake flag.
  int  hist[S+1];
  bit  m_sts[8];
  bit  m_wake;
  initial begin
    foreach (hist[j]) hist[j] = 1;
    foreach (m_sts[j]) m_sts[j] = 0;
    m_wake = 0;
  end

  always @(posedge clk) begin
    bit a_evt;
    if (!rst_n) begin
      foreach (hist[j]) hist[j] = 1;
      foreach (m_sts[j]) m_sts[j] = 0;
      m_wake = 0;
    end else begin
      a_evt = (hist[S-1] == 0) && (hist[S] == 1);
      for (int b = 0; b < 8; b++) if (wr_en && wr_data[b]) m_sts[b] = 0;
      for (int n = 0; n < 4; n++) if (host_evt[n]) m_sts[n+1] = 1;
      if (ntf) m_sts[0] = 1;
      if (a_evt) m_sts[5] = 1;
      if (tcmd && !asleep) m_sts[6] = 1;
      m_wake = a_evt || (tcmd && asleep) || (ntf && ntf_wake_en);
      for (int j = S; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = alert_n;
    end
  end

  always @(negedge clk) begin
    int e_sts, e_irq, e_smi;
    bit host_pend;
    if (wake) wake_cnt++;
    if (rst_n) begin
      e_sts = 0;
      for (int b = 0; b < 8; b++) if (m_sts[b]) e_sts += (1 << b);
      host_pend = m_sts[1] || m_sts[2] || m_sts[3] || m_sts[4];
      e_irq = 0; e_smi = 0;
      if (host_pend && irq_en) begin
        if (smi_en) e_smi = 1; else e_irq = 1;
      end
      if (m_sts[5] && !alert_dis) begin
        if (smi_en) e_smi = 1;
        else if (irq_en) e_irq = 1;
      end
      if (m_sts[0] && ntf_irq_en) begin
        if (smi_en) e_smi = 1; else e_irq = 1;
      end
      if (m_sts[6]) e_smi = 1;
      chk("R9", "model status", status, e_sts);
      chk("R4", "model irq", irq, e_irq);
      chk("R3", "model smi", smi, e_smi);
      chk("R10", "model wake", wake, m_wake);
    end
  end

  task automatic cyc();
    @(posedge clk); #5;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    @(negedge clk);
    chk("R1", "reset status", status, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset smi", smi, 0);
    chk("R1", "reset wake", wake, 0);
    cyc(); rst_n = 1'b1;
    cyc();

    // Host bits routed by enables
    host_evt = 4'b0100; cyc(); host_evt = 4'h0;
    @(negedge clk);
    chk("R5", "host status", status, 8'h08);
    chk("R5", "irq with en off", irq, 0);
    chk("R5", "smi with en off", smi, 0);
    cyc(); irq_en = 1'b1;
    @(negedge clk);
    chk("R5", "host irq", irq, 1);
    cyc(); smi_en = 1'b1;
    @(negedge clk);
    chk("R5", "host smi", smi, 1);
    chk("R5", "host irq off when smi", irq, 0);
    cyc(); wr_en = 1'b1; wr_data = 8'hF7; cyc(); wr_en = 1'b0;
    @(negedge clk);
    chk("R9", "zero write keeps bit", status, 8'h08);
    cyc(); wr_en = 1'b1; wr_data = 8'h08; cyc(); wr_en = 1'b0;
    @(negedge clk);
    chk("R9", "w1c clears", status, 0);
    chk("R11", "smi drops on clear", smi, 0);

    // Alert
    cyc(); irq_en = 1'b0; smi_en = 1'b0; alert_dis = 1'b1; wake_cnt = 0;
    alert_n = 1'b0;
    repeat (6) cyc();
    @(negedge clk);
    chk("R2", "alert status", status, 8'h20);
    chk("R10", "one wake pulse", wake_cnt, 1);
    chk("R3", "alert smi disabled", smi, 0);
    chk("R4", "alert irq disabled", irq, 0);
    cyc(); smi_en = 1'b1; alert_dis = 1'b0;
    @(negedge clk);
    chk("R3", "alert smi", smi, 1);
    cyc(); smi_en = 1'b0; irq_en = 1'b1;
    @(negedge clk);
    chk("R4", "alert irq", irq, 1);
    chk("R4", "alert no smi", smi, 0);
    cyc(); alert_dis = 1'b1;
    @(negedge clk);
    chk("R4", "alert irq blocked", irq, 0);
    cyc(); wr_en = 1'b1; wr_data = 8'hFF; cyc(); wr_en = 1'b0;
    repeat (3) cyc();
    @(negedge clk);
    chk("R2", "held alert no reset", status, 0);
    chk("R10", "held alert single wake", wake_cnt, 1);
    cyc(); alert_n = 1'b1; alert_dis = 1'b0; irq_en = 1'b0;
    repeat (4) cyc();

    // Target command
    asleep = 1'b1; wake_cnt = 0; tcmd = 1'b1; cyc(); tcmd = 1'b0;
    @(negedge clk);
    chk("R6", "asleep wake", wake, 1);
    chk("R6", "asleep no status", status, 0);
    chk("R6", "asleep no smi", smi, 0);
    cyc();
    @(negedge clk);
    chk("R10", "wake one cycle", wake, 0);
    cyc(); asleep = 1'b0; tcmd = 1'b1; cyc(); tcmd = 1'b0;
    @(negedge clk);
    chk("R6", "awake status", status, 8'h40);
    chk("R6", "awake smi", smi, 1);
    chk("R6", "awake no wake", wake, 0);
    cyc(); wr_en = 1'b1; wr_data = 8'h40; cyc(); wr_en = 1'b0;
    @(negedge clk);
    chk("R11", "smi level drops", smi, 0);

    // Notify
    cyc(); ntf_wake_en = 1'b1; ntf_irq_en = 1'b1; ntf = 1'b1; cyc(); ntf = 1'b0;
    @(negedge clk);
    chk("R7", "notify status", status, 8'h01);
    chk("R7", "notify wake", wake, 1);
    chk("R7", "notify irq", irq, 1);
    cyc(); smi_en = 1'b1;
    @(negedge clk);
    chk("R7", "notify smi", smi, 1);
    chk("R7", "notify irq gone", irq, 0);
    cyc(); ntf_irq_en = 1'b0;
    @(negedge clk);
    chk("R11", "notify smi off", smi, 0);
    cyc(); wr_en = 1'b1; wr_data = 8'hFF; cyc(); wr_en = 1'b0;

    // Additive, with a clear in the same cycle as the sets
    cyc(); smi_en = 1'b0; irq_en = 1'b1; ntf_irq_en = 1'b1;
    host_evt = 4'b1000; ntf = 1'b1; tcmd = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
    cyc(); host_evt = 4'h0; ntf = 1'b0; tcmd = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk("R9", "set beats clear", status, 8'h51);
    chk("R8", "additive irq", irq, 1);
    chk("R8", "additive smi", smi, 1);
    chk("R8", "additive wake", wake, 1);

    // Random traffic against the reference model
    for (int t = 0; t < 3000; t++) begin
      cyc();
      host_evt = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      ntf  = ($urandom_range(0, 11) == 0);
      tcmd = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 9) == 0) alert_n = ~alert_n;
      if ($urandom_range(0, 15) == 0) begin
        {irq_en, smi_en, alert_dis, ntf_irq_en, ntf_wake_en, asleep} = 6'($urandom);
      end
      wr_en = ($urandom_range(0, 5) == 0);
      wr_data = 8'($urandom);
    end
    cyc(); wr_en = 1'b0;
    cyc();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule